// File: doc/BRIEF.md
# PCI Transaction Timeout Watchdog

This block sits beside a PCI bus master and watches each transaction it issues. It enforces two limits, each programmable. The first is how long the master may wait for target-ready (TRDY#) within one data phase. The second is how many target retries one transaction may take. When either limit is broken, a sticky unrecoverable-error flag goes high. Software clears the flag by writing 1 to it. The watchdog keeps monitoring later transactions while the flag is set.

Two 8-bit limit registers and a status byte sit behind a simple register port. A write takes effect at the clock edge. Reads are combinational on the address.

- **Wait limit:** the wait-limit byte, multiplied by 32, gives the limit as a count of clock cycles.
- **Retry limit:** the retry-limit byte is the highest retry count that is still allowed.
- **Disable:** a byte of 00h turns off the matching check.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `pci_xact_watchdog`

## Requirements
- R1: After reset, address 40h (wait limit) reads 00h, address 41h (retry limit) reads 80h, address 42h (status) reads 00h, and `ue_flag` is low.
- R2: A write to 40h or 41h stores all 8 bits of `reg_wdata`. `reg_rdata` shows the byte at `reg_addr` in the same cycle. Status reads as bit 0 = flag and bits 7:1 = 0. Any other address reads 00h, and writes to it change nothing.
- R3: The wait counter counts sampled cycles in which `xact_active` is high and `trdy_n` and `irdy_n` are not both low. It clears when `xact_active` is low, on a transfer (both low), or on `retry_term`. It saturates rather than wrapping. A data phase shorter than the limit raises no error.
- R4: Suppose the wait-limit byte L is nonzero and L*32 consecutive wait cycles have been sampled in one data phase. Then `ue_flag` is high after the next clock edge, whatever the inputs are in that cycle.
- R5: With the wait-limit byte at 00h, no number of wait cycles raises `ue_flag`.
- R6: The retry counter increments on each sampled `retry_term` and clears on a sampled `xact_done`. It saturates rather than wrapping. Suppose the retry-limit byte N is nonzero and the count exceeds N after an edge. Then `ue_flag` is high after the following edge.
- R7: With the retry-limit byte at 00h, no number of retries raises `ue_flag`.
- R8: Once set, `ue_flag` stays high until a write to 42h with bit 0 = 1. A write with bit 0 = 0 leaves it set. If a limit is broken in the same cycle as a clearing write, the flag stays set. Monitoring continues while the flag is set.
- R9: A limit write is used from the next comparison on. If a counter already lies beyond the new limit, `ue_flag` rises at the edge after the write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_active | input | 1 | High while a transaction is in progress |
| trdy_n | input | 1 | Target ready, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| retry_term | input | 1 | One-cycle pulse: target ended the transaction with retry |
| xact_done | input | 1 | One-cycle pulse: transaction ended other than by retry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| ue_flag | output | 1 | Sticky unrecoverable-error flag |

## Verification
A register write is visible on `reg_rdata` after the write's edge. Each counter holds the inputs sampled at an edge. The error compare looks at those registered counts, so `ue_flag` follows the edge where a count reaches its limit by exactly one clock. The retry error therefore appears two edges after the offending retry is sampled. The lowered-limit case appears two edges after the write is presented.

The bench drives inputs at the falling edge and compares outputs 1 ns after the rising edge. Its per-cycle reference model applies the same edge ordering. Directed cases check the flag both in the cycle before it is due and in the cycle it is due.

// File: rtl/xwd_pkg.sv
package xwd_pkg;
  // Index of each limit register in the flattened limit vector.
  typedef enum int {
    LIM_TRDY  = 0,
    LIM_RETRY = 1
  } xwd_lim_e;

  localparam int XWD_NUM_LIM = 2;
endpackage

// File: rtl/xwd_cfg_regs.sv
module xwd_cfg_regs #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int NUM_LIM = 2,
  parameter logic [NUM_LIM*ADDR_W-1:0] LIM_OFS = {8'h41, 8'h40},
  parameter logic [NUM_LIM*DATA_W-1:0] LIM_RST = {8'h80, 8'h00},
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h42
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      ue_flag,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_LIM*DATA_W-1:0] lim_flat,
  output logic                      ue_clr
);
  // One limit register per offset.
  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    logic [DATA_W-1:0] lim_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lim_q <= LIM_RST[g*DATA_W +: DATA_W];
      end else if (wr_en && addr == LIM_OFS[g*ADDR_W +: ADDR_W]) begin
        lim_q <= wdata;
      end
    end

    assign lim_flat[g*DATA_W +: DATA_W] = lim_q;
  end

  // Combinational read mux.
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_LIM; i++) begin
      if (addr == LIM_OFS[i*ADDR_W +: ADDR_W]) begin
        rdata = lim_flat[i*DATA_W +: DATA_W];
      end
    end
    if (addr == STAT_OFS) begin
      rdata = {{(DATA_W-1){1'b0}}, ue_flag};
    end
  end

  // Write-one-to-clear on status bit 0.
  assign ue_clr = wr_en && (addr == STAT_OFS) && wdata[0];
endmodule

// File: rtl/xwd_wait_timer.sv
module xwd_wait_timer #(
  parameter int DATA_W   = 8,
  parameter int LOW_ZERO = 5,
  localparam int WAIT_W  = DATA_W + LOW_ZERO + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xact_active,
  input  logic              xfer,
  input  logic              retry_term,
  input  logic [DATA_W-1:0] lim,
  output logic [WAIT_W-1:0] cnt,
  output logic              hit
);
  logic [WAIT_W-1:0] lim_ext;

  // The limit byte sits above LOW_ZERO zero bits.
  assign lim_ext = {1'b0, lim, {LOW_ZERO{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!xact_active || xfer || retry_term) begin
      cnt <= '0;
    end else if (cnt != {WAIT_W{1'b1}}) begin
      cnt <= cnt + WAIT_W'(1);
    end
  end

  assign hit = (lim != '0) && (cnt >= lim_ext);
endmodule

// File: rtl/xwd_retry_counter.sv
module xwd_retry_counter #(
  parameter int DATA_W  = 8,
  localparam int CNT_W  = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retry_term,
  input  logic              xact_done,
  input  logic [DATA_W-1:0] lim,
  output logic [CNT_W-1:0]  cnt,
  output logic              hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (xact_done) begin
      cnt <= '0;
    end else if (retry_term && cnt != {CNT_W{1'b1}}) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign hit = (lim != '0) && (cnt > {1'b0, lim});
endmodule

// File: rtl/pci_xact_watchdog.sv
module pci_xact_watchdog
  import xwd_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int LOW_ZERO = 5,
  parameter logic [ADDR_W-1:0] TRDY_OFS  = 8'h40,
  parameter logic [ADDR_W-1:0] RETRY_OFS = 8'h41,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h42,
  parameter logic [DATA_W-1:0] TRDY_RST  = 8'h00,
  parameter logic [DATA_W-1:0] RETRY_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xact_active,
  input  logic              trdy_n,
  input  logic              irdy_n,
  input  logic              retry_term,
  input  logic              xact_done,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ue_flag
);
  localparam int WAIT_W = DATA_W + LOW_ZERO + 1;
  localparam int RTY_W  = DATA_W + 1;

  logic [XWD_NUM_LIM*DATA_W-1:0] lim_flat;
  logic [DATA_W-1:0] trdy_lim, retry_lim;
  logic [WAIT_W-1:0] wait_cnt;
  logic [RTY_W-1:0]  retry_cnt;
  logic wait_hit, retry_hit, ue_clr, xfer;

  assign xfer      = !trdy_n && !irdy_n;
  assign trdy_lim  = lim_flat[int'(LIM_TRDY)*DATA_W +: DATA_W];
  assign retry_lim = lim_flat[int'(LIM_RETRY)*DATA_W +: DATA_W];

  xwd_cfg_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_LIM (XWD_NUM_LIM),
    .LIM_OFS ({RETRY_OFS, TRDY_OFS}),
    .LIM_RST ({RETRY_RST, TRDY_RST}),
    .STAT_OFS(STAT_OFS)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .ue_flag (ue_flag),
    .rdata   (reg_rdata),
    .lim_flat(lim_flat),
    .ue_clr  (ue_clr)
  );

  xwd_wait_timer #(
    .DATA_W  (DATA_W),
    .LOW_ZERO(LOW_ZERO)
  ) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .xact_active(xact_active),
    .xfer       (xfer),
    .retry_term (retry_term),
    .lim        (trdy_lim),
    .cnt        (wait_cnt),
    .hit        (wait_hit)
  );

  xwd_retry_counter #(
    .DATA_W(DATA_W)
  ) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .retry_term(retry_term),
    .xact_done (xact_done),
    .lim       (retry_lim),
    .cnt       (retry_cnt),
    .hit       (retry_hit)
  );

  // Sticky error flag: a new violation wins over a clearing write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ue_flag <= 1'b0;
    end else if (wait_hit || retry_hit) begin
      ue_flag <= 1'b1;
    end else if (ue_clr) begin
      ue_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/xwd_checker.sv
module xwd_checker #(
  parameter int DATA_W   = 8,
  parameter int LOW_ZERO = 5,
  localparam int WAIT_W  = DATA_W + LOW_ZERO + 1,
  localparam int RTY_W   = DATA_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ue_flag,
  input logic              ue_clr,
  input logic              xfer,
  input logic              xact_active,
  input logic              xact_done,
  input logic [DATA_W-1:0] trdy_lim,
  input logic [DATA_W-1:0] retry_lim,
  input logic [WAIT_W-1:0] wait_cnt,
  input logic [RTY_W-1:0]  retry_cnt
);
  logic [WAIT_W-1:0] wait_lim_ext;
  assign wait_lim_ext = {1'b0, trdy_lim, {LOW_ZERO{1'b0}}};

  // R3: a transfer ends the data phase and clears the wait count.
  assert_wait_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_active && xfer) |=> (wait_cnt == '0));

  // R4: a wait count at or past the limit sets the flag.
  assert_wait_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_lim != '0 && wait_cnt >= wait_lim_ext) |=> ue_flag);

  // R5, R7: with both limits at zero, a clear flag stays clear.
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ue_flag && trdy_lim == '0 && retry_lim == '0) |=> !ue_flag);

  // R6: a completed transaction clears the retry count.
  assert_retry_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xact_done |=> (retry_cnt == '0));

  // R6: a retry count beyond the limit sets the flag.
  assert_retry_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_lim != '0 && retry_cnt > {1'b0, retry_lim}) |=> ue_flag);

  // R8: the flag holds until a clearing write.
  assert_ue_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_flag && !ue_clr) |=> ue_flag);
endmodule

bind pci_xact_watchdog xwd_checker #(
  .DATA_W  (DATA_W),
  .LOW_ZERO(LOW_ZERO)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ue_flag    (ue_flag),
  .ue_clr     (ue_clr),
  .xfer       (xfer),
  .xact_active(xact_active),
  .xact_done  (xact_done),
  .trdy_lim   (trdy_lim),
  .retry_lim  (retry_lim),
  .wait_cnt   (wait_cnt),
  .retry_cnt  (retry_cnt)
);

// File: tb/tb_pci_xact_watchdog.sv
`timescale 1ns/1ps
module tb_pci_xact_watchdog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xact_active = 1'b0, trdy_n = 1'b1, irdy_n = 1'b1;
  logic retry_term = 1'b0, xact_done = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h40, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic ue_flag;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // Reference model state.
  logic [7:0] m_trdy = 8'h00, m_retry = 8'h80;
  bit m_ue = 1'b0;
  int m_wcnt = 0, m_rcnt = 0;

  always #10 clk = ~clk;

  pci_xact_watchdog dut (
    .clk(clk), .rst_n(rst_n), .xact_active(xact_active), .trdy_n(trdy_n),
    .irdy_n(irdy_n), .retry_term(retry_term), .xact_done(xact_done),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ue_flag(ue_flag)
  );

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'h40:   return m_trdy;
      8'h41:   return m_retry;
      8'h42:   return {7'b0, m_ue};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge,
  // compare 1 ns after it.
  task automatic cyc(input bit act, input bit trn, input bit irn, input bit rty,
                     input bit dn, input bit wr, input logic [7:0] ad, input logic [7:0] wd);
    bit hw, hr, clr, xf;
    @(negedge clk);
    xact_active = act; trdy_n = trn; irdy_n = irn; retry_term = rty;
    xact_done = dn; reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    @(posedge clk);
    hw  = (m_trdy != 0) && (m_wcnt >= int'(m_trdy) * 32);
    hr  = (m_retry != 0) && (m_rcnt > int'(m_retry));
    clr = wr && ad == 8'h42 && wd[0];
    xf  = !trn && !irn;
    if (hw || hr) m_ue = 1'b1; else if (clr) m_ue = 1'b0;
    if (!act || xf || rty) m_wcnt = 0; else if (m_wcnt < 16383) m_wcnt++;
    if (dn) m_rcnt = 0; else if (rty && m_rcnt < 511) m_rcnt++;
    if (wr && ad == 8'h40) m_trdy = wd;
    if (wr && ad == 8'h41) m_retry = wd;
    #1;
    chk("R4/R6/R8 model flag", {7'b0, ue_flag}, {7'b0, m_ue});
    chk("R2 model read", reg_rdata, model_read(ad));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 1, 0, 0, 0, 8'h40, 0);
  endtask
  task automatic waits(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 0, 0, 8'h40, 0);
  endtask
  task automatic xfer1();
    cyc(1, 0, 0, 0, 0, 0, 8'h40, 0);
  endtask
  task automatic retries(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 1, 0, 0, 8'h41, 0);
  endtask
  task automatic done1();
    cyc(0, 1, 1, 0, 1, 0, 8'h42, 0);
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(0, 1, 1, 0, 0, 1, a, d);
  endtask
  task automatic rd(input logic [7:0] a);
    cyc(0, 1, 1, 0, 0, 0, a, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(8'h40); chk("R1 wait limit", reg_rdata, 8'h00);
    rd(8'h41); chk("R1 retry limit", reg_rdata, 8'h80);
    rd(8'h42); chk("R1 status", reg_rdata, 8'h00);
    chk("R1 flag", {7'b0, ue_flag}, 8'h00);

    // R2 read/write, unmapped address
    wr(8'h40, 8'hA5); rd(8'h40); chk("R2 wait limit", reg_rdata, 8'hA5);
    wr(8'h41, 8'h5C); rd(8'h41); chk("R2 retry limit", reg_rdata, 8'h5C);
    wr(8'h43, 8'hFF); rd(8'h43); chk("R2 unmapped read", reg_rdata, 8'h00);
    rd(8'h40); chk("R2 unmapped write ignored", reg_rdata, 8'hA5);
    wr(8'h40, 8'h01); wr(8'h41, 8'h00);

    // R3 short phase, R4 timeout at 32 waits
    waits(31); xfer1(); idle(2);
    chk("R3 short phase no error", {7'b0, ue_flag}, 8'h00);
    waits(32); chk("R4 not yet due", {7'b0, ue_flag}, 8'h00);
    xfer1();   chk("R4 timeout flag", {7'b0, ue_flag}, 8'h01);
    idle(1);

    // R8 sticky, write-one-to-clear, monitoring continues
    wr(8'h42, 8'hFE); chk("R8 bit0 zero keeps flag", {7'b0, ue_flag}, 8'h01);
    wr(8'h42, 8'h01); chk("R8 clear", {7'b0, ue_flag}, 8'h00);
    waits(32); xfer1(); chk("R8 monitoring continues", {7'b0, ue_flag}, 8'h01);
    idle(1); wr(8'h42, 8'h01);
    waits(40);
    cyc(1, 1, 0, 0, 0, 1, 8'h42, 8'h01);
    chk("R8 set beats clear", {7'b0, ue_flag}, 8'h01);
    idle(2); wr(8'h42, 8'h01); chk("R8 cleared", {7'b0, ue_flag}, 8'h00);

    // R5 wait check disabled
    wr(8'h40, 8'h00); waits(300); xfer1(); idle(1);
    chk("R5 disabled wait check", {7'b0, ue_flag}, 8'h00);

    // R6 retry limit 2
    wr(8'h41, 8'h02);
    retries(2); idle(1); chk("R6 at limit", {7'b0, ue_flag}, 8'h00);
    done1(); retries(2); idle(2); chk("R6 done clears count", {7'b0, ue_flag}, 8'h00);
    done1(); retries(3); chk("R6 not yet due", {7'b0, ue_flag}, 8'h00);
    idle(1); chk("R6 retry flag", {7'b0, ue_flag}, 8'h01);
    done1(); wr(8'h42, 8'h01);

    // R7 retry check disabled
    wr(8'h41, 8'h00); retries(20); done1(); idle(1);
    chk("R7 disabled retry check", {7'b0, ue_flag}, 8'h00);

    // R9 lowered limits
    waits(100);
    cyc(1, 1, 0, 0, 0, 1, 8'h40, 8'h01); chk("R9 write edge", {7'b0, ue_flag}, 8'h00);
    waits(1); chk("R9 wait limit lowered", {7'b0, ue_flag}, 8'h01);
    idle(1); wr(8'h42, 8'h01); wr(8'h40, 8'h00);
    wr(8'h41, 8'h10); retries(5);
    wr(8'h41, 8'h02); chk("R9 retry write edge", {7'b0, ue_flag}, 8'h00);
    idle(1); chk("R9 retry limit lowered", {7'b0, ue_flag}, 8'h01);
    done1(); wr(8'h42, 8'h01);

    // Constrained random traffic against the model (R3, R4, R6, R8)
    wr(8'h40, 8'h01); wr(8'h41, 8'h03);
    for (int i = 0; i < 4000; i++) begin
      bit act, trn, irn, rty, dn, w;
      logic [7:0] a, d;
      act = ($urandom % 16) != 0;
      trn = ($urandom % 40) != 0;
      irn = ($urandom % 8) == 0;
      rty = ($urandom % 30) == 0;
      dn  = ($urandom % 25) == 0;
      w   = ($urandom % 50) == 0;
      a   = 8'h40 + 8'($urandom % 4);
      d   = 8'($urandom % 4);
      if (w && a == 8'h43) d = 8'h01;
      cyc(act, trn, irn, rty, dn, w, w && a == 8'h43 ? 8'h42 : a, d);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule